// File: doc/BRIEF.md
# Coprocessor Host Control Register File

A byte-wide register bank that sits between a host CPU and a coprocessor. The host writes and reads it one byte at a time through an 8-bit offset. It holds the coprocessor's DMA parameters and cache parameters. It also holds the program bank and counter, wait-state settings, interrupt and suspend control, a 32-byte vector table and sixteen 24-bit general registers.

Some writes have side effects, and several of them depend on whether the coprocessor is halted. While the core is halted, writing the top byte of the DMA target requests a transfer. Writing the cache page byte requests a cache fill. Writing the program counter byte releases the core at the stored bank and counter. Each request leaves the block as a one-cycle pulse in the cycle after the write. A group of offsets starts a suspend, either with no end or lasting a fixed multiple of 32 cycles, and a further offset ends it. The core, the DMA engine and the cache are outside the block: they appear only as the busy, running and interrupt-request inputs and as the start pulses and field outputs.

Reads are combinational from `addr_i`. Writes take effect on the rising clock edge on which `wr_i` is high.

Top module: `cpx_ctrl_regs`

## Requirements
- R1: After reset `halt_o` is 1. All start pulses, `irq_o` and `susp_o` are 0. Every stored field reads back 0.
- R2: The DMA source is at 0x40 (low byte) to 0x42. The DMA length is at 0x43 to 0x44. The DMA target is at 0x45 to 0x47. All three are little-endian and read back. A write to 0x47 while halted pulses `dma_start_o` high for exactly the next cycle. The same write while running only stores the byte.
- R3: Offset 0x48 stores the cache page in bit 0, and a write to it while halted pulses `cache_fill_o` for one cycle. The 24-bit cache base is at 0x49 to 0x4B, little-endian. Offset 0x4C stores two lock bits in bits [1:0]. At most one start pulse is high in any cycle.
- R4: The program bank is at 0x4D (low byte) to 0x4E, and the program counter is at 0x4F. A write to 0x4F while halted clears halt and pulses `exec_start_o` for one cycle. In the same cycle it presents the stored bank and the written counter on `start_bank_o` and `start_pc_o`. While running, the write only stores the byte.
- R5: Offset 0x50 stores the RAM wait count in bits [2:0] and the ROM wait count in bits [6:4]. Bits 3 and 7 read as 0.
- R6: Bit 0 of 0x51 is the IRQ enable and reads back. `irq_req_i` sets the internal IRQ flag, and it asserts `irq_o` only when the enable was already set. Writing 0x51 with bit 0 = 1 clears both the flag and `irq_o`. Writing 0x5E clears only the flag. A request in the same cycle as either clear wins.
- R7: A write to 0x53 sets halt, whatever the data.
- R8: A write to 0x55 raises `susp_o` until a write to 0x5D. A write to 0x56 through 0x5C raises `susp_o` for exactly (offset - 0x55) * 32 cycles. A new suspend write restarts the length.
- R9: Reads of 0x53-0x57, 0x59, 0x5B-0x5F return a status byte. Bit 0 is suspend active, bit 1 is the IRQ flag, bit 6 is `running_i`, bit 7 is `busy_i`, and the other bits are 0.
- R10: Offsets 0x60 to 0x7F form a 32-byte read/write vector table.
- R11: Offsets 0x80-0xAF and their mirror 0xC0-0xEF access sixteen 24-bit registers. The register index is (offset & 0x3F) / 3, and the byte lane is the remainder (lane 0 is the low byte).
- R12: All other offsets read 0x00, and writes to them change no state. These offsets are 0x00-0x3F, 0x52, 0x58 and 0x5A when read, 0xB0-0xBF and 0xF0-0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 8 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| busy_i | input | 1 | Coprocessor busy, shown in status bit 7 |
| running_i | input | 1 | Coprocessor running, shown in status bit 6 |
| irq_req_i | input | 1 | Interrupt request from the core |
| dma_src_o | output | 24 | DMA source |
| dma_len_o | output | 16 | DMA length |
| dma_tgt_o | output | 24 | DMA target |
| dma_start_o | output | 1 | DMA start pulse |
| cache_page_o | output | 1 | Cache page select |
| cache_base_o | output | 24 | Cache base |
| cache_lock_o | output | 2 | Cache lock bits |
| cache_fill_o | output | 1 | Cache fill start pulse |
| start_bank_o | output | 16 | Program bank latched at release |
| start_pc_o | output | 8 | Program counter latched at release |
| exec_start_o | output | 1 | Execution start pulse |
| halt_o | output | 1 | Core halted |
| wait_ram_o | output | 3 | RAM wait count |
| wait_rom_o | output | 3 | ROM wait count |
| irq_o | output | 1 | Host interrupt line |
| susp_o | output | 1 | Suspend active |

## Verification
The core's interrupt request and a host clearing write can land in the same cycle: a write of 1 to 0x51, or any write to 0x5E. The bench provokes this by holding `irq_req_i` high on the exact clock edge of such a write, with the enable already set, and then reads the status flag and watches `irq_o`. The reference model gives the request priority, so after that edge both the flag and the host line must be set. A second overlap is a new suspend write while a timed suspend is counting down. Here the model expects the new length to restart from the write.

// File: rtl/cpx_regs_pkg.sv
package cpx_regs_pkg;

  localparam logic [7:0] OFF_DMA_SRC0 = 8'h40;
  localparam logic [7:0] OFF_DMA_SRC1 = 8'h41;
  localparam logic [7:0] OFF_DMA_SRC2 = 8'h42;
  localparam logic [7:0] OFF_DMA_LEN0 = 8'h43;
  localparam logic [7:0] OFF_DMA_LEN1 = 8'h44;
  localparam logic [7:0] OFF_DMA_TGT0 = 8'h45;
  localparam logic [7:0] OFF_DMA_TGT1 = 8'h46;
  localparam logic [7:0] OFF_DMA_TGT2 = 8'h47;
  localparam logic [7:0] OFF_CPAGE    = 8'h48;
  localparam logic [7:0] OFF_CBASE0   = 8'h49;
  localparam logic [7:0] OFF_CBASE1   = 8'h4A;
  localparam logic [7:0] OFF_CBASE2   = 8'h4B;
  localparam logic [7:0] OFF_CLOCK    = 8'h4C;
  localparam logic [7:0] OFF_PBANK0   = 8'h4D;
  localparam logic [7:0] OFF_PBANK1   = 8'h4E;
  localparam logic [7:0] OFF_PCNT     = 8'h4F;
  localparam logic [7:0] OFF_WAIT     = 8'h50;
  localparam logic [7:0] OFF_IRQ_CTL  = 8'h51;
  localparam logic [7:0] OFF_HALT     = 8'h53;
  localparam logic [7:0] OFF_SUSP_INF = 8'h55;
  localparam logic [7:0] OFF_SUSP_MAX = 8'h5C;
  localparam logic [7:0] OFF_RESUME   = 8'h5D;
  localparam logic [7:0] OFF_IRQ_ACK  = 8'h5E;

  typedef struct packed {
    logic       busy;
    logic       running;
    logic [3:0] zero;
    logic       irq_flag;
    logic       susp;
  } status_t;

  function automatic logic is_status(input logic [7:0] a);
    return a inside {8'h53, 8'h54, 8'h55, 8'h56, 8'h57, 8'h59,
                     8'h5B, 8'h5C, 8'h5D, 8'h5E, 8'h5F};
  endfunction

  function automatic logic [23:0] put_lane(input logic [23:0] old,
                                           input logic [1:0]  lane,
                                           input logic [7:0]  d);
    logic [23:0] r;
    r = old;
    case (lane)
      2'd0:    r[7:0]   = d;
      2'd1:    r[15:8]  = d;
      default: r[23:16] = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cpx_vec_table.sv
module cpx_vec_table #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] idx_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);

  logic [7:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (we_i && (idx_i == AW'(i))) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/cpx_gpr_bank.sv
module cpx_gpr_bank #(
  parameter int NUM = 16,
  parameter int W   = 24,
  localparam int LANES = W / 8,
  localparam int IW    = $clog2(NUM),
  localparam int LW    = $clog2(LANES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [LW-1:0] lane_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);

  localparam logic [LW-1:0] LANE_MAX = LW'(LANES - 1);

  logic [7:0] byte_q [NUM][LANES];

  for (genvar r = 0; r < NUM; r++) begin : g_reg
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) byte_q[r][l] <= '0;
        else if (we_i && (idx_i == IW'(r)) && (lane_i == LW'(l)))
          byte_q[r][l] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (lane_i <= LANE_MAX) rdata_o = byte_q[idx_i][lane_i];
  end

endmodule

// File: rtl/cpx_susp_timer.sv
module cpx_susp_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,   // 0 = no end
  input  logic          stop_i,
  output logic          active_o
);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (stop_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= len_i;
    end else if (act_q && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) act_q <= 1'b0;
    end
  end

  assign active_o = act_q;

endmodule

// File: rtl/cpx_ctrl_regs.sv
module cpx_ctrl_regs
  import cpx_regs_pkg::*;
#(
  parameter int NUM_GPR    = 16,
  parameter int GPR_W      = 24,
  parameter int VEC_DEPTH  = 32,
  parameter int SUSP_STEP  = 32,
  parameter int SUSP_CODES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [7:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        busy_i,
  input  logic        running_i,
  input  logic        irq_req_i,
  output logic [23:0] dma_src_o,
  output logic [15:0] dma_len_o,
  output logic [23:0] dma_tgt_o,
  output logic        dma_start_o,
  output logic        cache_page_o,
  output logic [23:0] cache_base_o,
  output logic [1:0]  cache_lock_o,
  output logic        cache_fill_o,
  output logic [15:0] start_bank_o,
  output logic [7:0]  start_pc_o,
  output logic        exec_start_o,
  output logic        halt_o,
  output logic [2:0]  wait_ram_o,
  output logic [2:0]  wait_rom_o,
  output logic        irq_o,
  output logic        susp_o
);

  localparam int GPR_LANES = GPR_W / 8;
  localparam int GPR_IW    = $clog2(NUM_GPR);
  localparam int GPR_LW    = $clog2(GPR_LANES);
  localparam int GPR_BYTES = NUM_GPR * GPR_LANES;
  localparam int VEC_AW    = $clog2(VEC_DEPTH);
  localparam int SUSP_CW   = $clog2((SUSP_CODES - 1) * SUSP_STEP + 1);

  // Field registers
  logic [23:0] dma_src_q, dma_tgt_q, cbase_q;
  logic [15:0] dma_len_q, pbank_q, sbank_q;
  logic [7:0]  pcnt_q, spc_q;
  logic        cpage_q;
  logic [1:0]  clock_q;
  logic [2:0]  wram_q, wrom_q;
  logic        irq_en_q, irq_flag_q, irq_line_q;
  logic        halt_q;
  logic        dma_go_q, fill_go_q, exec_go_q;

  // Decode
  logic        vec_hit, gpr_hit;
  logic [5:0]  gpr_off;
  logic [GPR_IW-1:0] gpr_idx;
  logic [GPR_LW-1:0] gpr_lane;
  logic [7:0]  vec_rdata, gpr_rdata;
  logic        susp_start, susp_stop, susp_act;
  logic [3:0]  susp_code;
  logic [SUSP_CW-1:0] susp_len;
  status_t     status;

  assign vec_hit  = (addr_i >= 8'h60) && (addr_i < 8'h60 + 8'(VEC_DEPTH));
  assign gpr_off  = addr_i[5:0];
  assign gpr_hit  = addr_i[7] && (gpr_off < 6'(GPR_BYTES));
  assign gpr_idx  = GPR_IW'(gpr_off / 6'(GPR_LANES));
  assign gpr_lane = GPR_LW'(gpr_off % 6'(GPR_LANES));

  assign susp_start = wr_i && (addr_i >= OFF_SUSP_INF) && (addr_i <= OFF_SUSP_MAX);
  assign susp_stop  = wr_i && (addr_i == OFF_RESUME);
  assign susp_code  = addr_i[3:0] - OFF_SUSP_INF[3:0];
  assign susp_len   = SUSP_CW'(susp_code) * SUSP_CW'(SUSP_STEP);

  cpx_vec_table #(.DEPTH(VEC_DEPTH)) u_vec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i && vec_hit),
    .idx_i   (addr_i[VEC_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (vec_rdata)
  );

  cpx_gpr_bank #(.NUM(NUM_GPR), .W(GPR_W)) u_gpr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i && gpr_hit),
    .idx_i   (gpr_idx),
    .lane_i  (gpr_lane),
    .wdata_i (wdata_i),
    .rdata_o (gpr_rdata)
  );

  cpx_susp_timer #(.CW(SUSP_CW)) u_susp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (susp_start),
    .len_i    (susp_len),
    .stop_i   (susp_stop),
    .active_o (susp_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_src_q  <= '0;
      dma_len_q  <= '0;
      dma_tgt_q  <= '0;
      cpage_q    <= 1'b0;
      cbase_q    <= '0;
      clock_q    <= '0;
      pbank_q    <= '0;
      pcnt_q     <= '0;
      sbank_q    <= '0;
      spc_q      <= '0;
      wram_q     <= '0;
      wrom_q     <= '0;
      irq_en_q   <= 1'b0;
      irq_flag_q <= 1'b0;
      irq_line_q <= 1'b0;
      halt_q     <= 1'b1;
      dma_go_q   <= 1'b0;
      fill_go_q  <= 1'b0;
      exec_go_q  <= 1'b0;
    end else begin
      dma_go_q  <= 1'b0;
      fill_go_q <= 1'b0;
      exec_go_q <= 1'b0;
      if (wr_i) begin
        case (addr_i)
          OFF_DMA_SRC0: dma_src_q <= put_lane(dma_src_q, 2'd0, wdata_i);
          OFF_DMA_SRC1: dma_src_q <= put_lane(dma_src_q, 2'd1, wdata_i);
          OFF_DMA_SRC2: dma_src_q <= put_lane(dma_src_q, 2'd2, wdata_i);
          OFF_DMA_LEN0: dma_len_q[7:0]  <= wdata_i;
          OFF_DMA_LEN1: dma_len_q[15:8] <= wdata_i;
          OFF_DMA_TGT0: dma_tgt_q <= put_lane(dma_tgt_q, 2'd0, wdata_i);
          OFF_DMA_TGT1: dma_tgt_q <= put_lane(dma_tgt_q, 2'd1, wdata_i);
          OFF_DMA_TGT2: begin
            dma_tgt_q <= put_lane(dma_tgt_q, 2'd2, wdata_i);
            dma_go_q  <= halt_q;
          end
          OFF_CPAGE: begin
            cpage_q   <= wdata_i[0];
            fill_go_q <= halt_q;
          end
          OFF_CBASE0: cbase_q <= put_lane(cbase_q, 2'd0, wdata_i);
          OFF_CBASE1: cbase_q <= put_lane(cbase_q, 2'd1, wdata_i);
          OFF_CBASE2: cbase_q <= put_lane(cbase_q, 2'd2, wdata_i);
          OFF_CLOCK:  clock_q <= wdata_i[1:0];
          OFF_PBANK0: pbank_q[7:0]  <= wdata_i;
          OFF_PBANK1: pbank_q[15:8] <= wdata_i;
          OFF_PCNT: begin
            pcnt_q <= wdata_i;
            if (halt_q) begin
              halt_q    <= 1'b0;
              exec_go_q <= 1'b1;
              sbank_q   <= pbank_q;
              spc_q     <= wdata_i;
            end
          end
          OFF_WAIT: begin
            wram_q <= wdata_i[2:0];
            wrom_q <= wdata_i[6:4];
          end
          OFF_IRQ_CTL: begin
            irq_en_q <= wdata_i[0];
            if (wdata_i[0]) begin
              irq_flag_q <= 1'b0;
              irq_line_q <= 1'b0;
            end
          end
          OFF_HALT:    halt_q     <= 1'b1;
          OFF_IRQ_ACK: irq_flag_q <= 1'b0;
          default: ;
        endcase
      end
      // request has priority over any clear in the same cycle
      if (irq_req_i) begin
        irq_flag_q <= 1'b1;
        if (irq_en_q) irq_line_q <= 1'b1;
      end
    end
  end

  always_comb begin
    status          = '0;
    status.busy     = busy_i;
    status.running  = running_i;
    status.irq_flag = irq_flag_q;
    status.susp     = susp_act;
  end

  always_comb begin
    rdata_o = '0;
    if (is_status(addr_i))  rdata_o = status;
    else if (vec_hit)       rdata_o = vec_rdata;
    else if (gpr_hit)       rdata_o = gpr_rdata;
    else begin
      case (addr_i)
        OFF_DMA_SRC0: rdata_o = dma_src_q[7:0];
        OFF_DMA_SRC1: rdata_o = dma_src_q[15:8];
        OFF_DMA_SRC2: rdata_o = dma_src_q[23:16];
        OFF_DMA_LEN0: rdata_o = dma_len_q[7:0];
        OFF_DMA_LEN1: rdata_o = dma_len_q[15:8];
        OFF_DMA_TGT0: rdata_o = dma_tgt_q[7:0];
        OFF_DMA_TGT1: rdata_o = dma_tgt_q[15:8];
        OFF_DMA_TGT2: rdata_o = dma_tgt_q[23:16];
        OFF_CPAGE:    rdata_o = {7'b0, cpage_q};
        OFF_CBASE0:   rdata_o = cbase_q[7:0];
        OFF_CBASE1:   rdata_o = cbase_q[15:8];
        OFF_CBASE2:   rdata_o = cbase_q[23:16];
        OFF_CLOCK:    rdata_o = {6'b0, clock_q};
        OFF_PBANK0:   rdata_o = pbank_q[7:0];
        OFF_PBANK1:   rdata_o = pbank_q[15:8];
        OFF_PCNT:     rdata_o = pcnt_q;
        OFF_WAIT:     rdata_o = {1'b0, wrom_q, 1'b0, wram_q};
        OFF_IRQ_CTL:  rdata_o = {7'b0, irq_en_q};
        default:      rdata_o = '0;
      endcase
    end
  end

  assign dma_src_o    = dma_src_q;
  assign dma_len_o    = dma_len_q;
  assign dma_tgt_o    = dma_tgt_q;
  assign dma_start_o  = dma_go_q;
  assign cache_page_o = cpage_q;
  assign cache_base_o = cbase_q;
  assign cache_lock_o = clock_q;
  assign cache_fill_o = fill_go_q;
  assign start_bank_o = sbank_q;
  assign start_pc_o   = spc_q;
  assign exec_start_o = exec_go_q;
  assign halt_o       = halt_q;
  assign wait_ram_o   = wram_q;
  assign wait_rom_o   = wrom_q;
  assign irq_o        = irq_line_q;
  assign susp_o       = susp_act;

endmodule

// File: rtl/cpx_ctrl_regs_chk.sv
module cpx_ctrl_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic [7:0] addr_i,
  input logic [7:0] wdata_i,
  input logic       irq_req_i,
  input logic       dma_start_o,
  input logic       cache_fill_o,
  input logic       exec_start_o,
  input logic       halt_o,
  input logic       irq_o,
  input logic       susp_o
);

  p_dma_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_start_o |-> $past(wr_i && (addr_i == 8'h47) && halt_o));

  p_fill_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_fill_o |-> $past(wr_i && (addr_i == 8'h48) && halt_o));

  p_single_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dma_start_o, cache_fill_o, exec_start_o}));

  p_exec_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |-> !halt_o);

  p_irq_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == 8'h51) && wdata_i[0] && !irq_req_i) |=> !irq_o);

  p_halt_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == 8'h53)) |=> halt_o);

  p_resume_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i == 8'h5D)) |=> !susp_o);

endmodule

bind cpx_ctrl_regs cpx_ctrl_regs_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_i         (wr_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .irq_req_i    (irq_req_i),
  .dma_start_o  (dma_start_o),
  .cache_fill_o (cache_fill_o),
  .exec_start_o (exec_start_o),
  .halt_o       (halt_o),
  .irq_o        (irq_o),
  .susp_o       (susp_o)
);

// File: tb/cpx_ctrl_regs_bench.sv
`timescale 1ns/1ps
module cpx_ctrl_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        busy = 1'b0, running = 1'b0, irq_req = 1'b0;
  logic [7:0]  rdata;
  logic [23:0] dma_src, dma_tgt, cache_base;
  logic [15:0] dma_len, start_bank;
  logic [7:0]  start_pc;
  logic        dma_start, cache_page, cache_fill, exec_start, halt, irq, susp;
  logic [1:0]  cache_lock;
  logic [2:0]  wait_ram, wait_rom;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  cpx_ctrl_regs u_cpx_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .busy_i(busy), .running_i(running), .irq_req_i(irq_req),
    .dma_src_o(dma_src), .dma_len_o(dma_len), .dma_tgt_o(dma_tgt),
    .dma_start_o(dma_start), .cache_page_o(cache_page), .cache_base_o(cache_base),
    .cache_lock_o(cache_lock), .cache_fill_o(cache_fill), .start_bank_o(start_bank),
    .start_pc_o(start_pc), .exec_start_o(exec_start), .halt_o(halt),
    .wait_ram_o(wait_ram), .wait_rom_o(wait_rom), .irq_o(irq), .susp_o(susp)
  );

  // ---------------- reference model ----------------
  logic [7:0] img [256];
  bit m_halt, m_dma, m_fill, m_exec, m_en, m_flag, m_line, m_susp;
  int m_cnt;
  logic [15:0] m_bank;
  logic [7:0]  m_pc;

  function automatic logic [7:0] wmask(input logic [7:0] a);
    if (a >= 8'h40 && a <= 8'h47) return 8'hFF;
    if (a == 8'h48) return 8'h01;
    if (a >= 8'h49 && a <= 8'h4B) return 8'hFF;
    if (a == 8'h4C) return 8'h03;
    if (a >= 8'h4D && a <= 8'h4F) return 8'hFF;
    if (a == 8'h50) return 8'h77;
    if (a == 8'h51) return 8'h01;
    if (a >= 8'h60 && a <= 8'hAF) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [7:0] canon(input logic [7:0] a);
    if (a >= 8'hC0 && a <= 8'hEF) return a - 8'h40;
    return a;
  endfunction

  function automatic bit stat_off(input logic [7:0] a);
    return (a >= 8'h53 && a <= 8'h5F) && a != 8'h58 && a != 8'h5A;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (stat_off(a)) return {busy, running, 4'b0, m_flag, m_susp};
    return img[canon(a)];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) img[i] = 8'h00;
      m_halt = 1; m_dma = 0; m_fill = 0; m_exec = 0;
      m_en = 0; m_flag = 0; m_line = 0; m_susp = 0; m_cnt = 0;
      m_bank = 0; m_pc = 0;
    end else begin
      bit sw;
      logic [7:0] a;
      m_dma = 0; m_fill = 0; m_exec = 0; sw = 0;
      a = canon(addr);
      if (wr) begin
        img[a] = (img[a] & ~wmask(a)) | (wdata & wmask(a));
        if (addr == 8'h47 && m_halt) m_dma = 1;
        if (addr == 8'h48 && m_halt) m_fill = 1;
        if (addr == 8'h4F && m_halt) begin
          m_halt = 0; m_exec = 1; m_bank = {img[8'h4E], img[8'h4D]}; m_pc = wdata;
        end
        if (addr == 8'h53) m_halt = 1;
        if (addr == 8'h51 && wdata[0]) begin m_flag = 0; m_line = 0; end
        if (addr == 8'h5E) m_flag = 0;
        if (addr >= 8'h55 && addr <= 8'h5C) begin
          sw = 1; m_susp = 1; m_cnt = (int'(addr) - 8'h55) * 32;
        end
        if (addr == 8'h5D) begin sw = 1; m_susp = 0; m_cnt = 0; end
      end
      if (!sw && m_susp && m_cnt != 0) begin
        m_cnt--;
        if (m_cnt == 0) m_susp = 0;
      end
      if (irq_req) begin
        m_flag = 1;
        if (img[8'h51][0] && !(wr && addr == 8'h51)) m_line = 1;
        else if (wr && addr == 8'h51 && m_en) m_line = 1;
      end
      m_en = img[8'h51][0];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison of control outputs
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R2 dma_start", dma_start, m_dma);
      chk("R3 cache_fill", cache_fill, m_fill);
      chk("R4 exec_start", exec_start, m_exec);
      chk("R4 start_bank", start_bank, m_bank);
      chk("R4 start_pc", start_pc, m_pc);
      chk("R7 halt", halt, m_halt);
      chk("R6 irq line", irq, m_line);
      chk("R8 suspend", susp, m_susp);
    end
  end

  task automatic wr_b(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic rd_b(input logic [7:0] a, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdata, exp_rd(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    // R1 reset state
    idle(1);
    chk("R1 halt", halt, 1);
    chk("R1 irq", irq, 0);
    chk("R1 susp", susp, 0);
    foreach (img[i]) if (i % 11 == 0) rd_b(8'(i), "R1 reset readback");
    rd_b(8'h53, "R1 status");

    // R2 DMA fields, start while halted
    wr_b(8'h40, 8'h11); wr_b(8'h41, 8'h22); wr_b(8'h42, 8'h33);
    wr_b(8'h43, 8'h44); wr_b(8'h44, 8'h55);
    wr_b(8'h45, 8'h66); wr_b(8'h46, 8'h77); wr_b(8'h47, 8'h88);
    chk("R2 dma_src", dma_src, 24'h332211);
    chk("R2 dma_len", dma_len, 16'h5544);
    chk("R2 dma_tgt", dma_tgt, 24'h887766);
    for (int i = 8'h40; i <= 8'h47; i++) rd_b(8'(i), "R2 readback");

    // R3 cache
    wr_b(8'h48, 8'hFF);
    wr_b(8'h49, 8'hA1); wr_b(8'h4A, 8'hB2); wr_b(8'h4B, 8'hC3);
    wr_b(8'h4C, 8'hFE);
    chk("R3 page", cache_page, 1);
    chk("R3 base", cache_base, 24'hC3B2A1);
    chk("R3 lock", cache_lock, 2'b10);
    for (int i = 8'h48; i <= 8'h4C; i++) rd_b(8'(i), "R3 readback");

    // R4 release
    wr_b(8'h4D, 8'h34); wr_b(8'h4E, 8'h12); wr_b(8'h4F, 8'h9A);
    chk("R4 start_bank", start_bank, 16'h1234);
    chk("R4 start_pc", start_pc, 8'h9A);
    chk("R4 halt cleared", halt, 0);
    // running: no pulses
    wr_b(8'h47, 8'h01); wr_b(8'h48, 8'h00); wr_b(8'h4F, 8'h55);
    chk("R4 pc stored while running", start_pc, 8'h9A);
    rd_b(8'h4F, "R4 readback pc");
    rd_b(8'h47, "R2 readback while running");
    // R7 halt again, then fill
    wr_b(8'h53, 8'h00);
    chk("R7 halt set", halt, 1);
    wr_b(8'h48, 8'h01);
    wr_b(8'h4F, 8'h07);

    // R5 wait
    wr_b(8'h50, 8'hFF);
    rd_b(8'h50, "R5 mask");
    wr_b(8'h50, 8'h35);
    chk("R5 ram", wait_ram, 5);
    chk("R5 rom", wait_rom, 3);
    rd_b(8'h50, "R5 readback");

    // R6 interrupt
    @(negedge clk); irq_req = 1; @(negedge clk); irq_req = 0;
    rd_b(8'h54, "R6 flag without enable");
    wr_b(8'h51, 8'h01);
    rd_b(8'h51, "R6 enable readback");
    rd_b(8'h54, "R6 flag cleared");
    @(negedge clk); irq_req = 1; @(negedge clk); irq_req = 0;
    chk("R6 line set", irq, 1);
    wr_b(8'h5E, 8'h00);
    rd_b(8'h54, "R6 ack clears flag");
    chk("R6 ack keeps line", irq, 1);
    wr_b(8'h51, 8'h01);
    chk("R6 enable write drops line", irq, 0);
    // coincident request and clear
    @(negedge clk); wr = 1; addr = 8'h51; wdata = 8'h01; irq_req = 1;
    @(negedge clk); wr = 0; irq_req = 0;
    chk("R6 request wins over 0x51 clear", irq, 1);
    rd_b(8'h54, "R6 flag after coincident clear");
    @(negedge clk); wr = 1; addr = 8'h5E; wdata = 8'h00; irq_req = 1;
    @(negedge clk); wr = 0; irq_req = 0;
    rd_b(8'h54, "R6 request wins over 0x5E");
    wr_b(8'h51, 8'h00);
    @(negedge clk); irq_req = 1; @(negedge clk); irq_req = 0;
    wr_b(8'h51, 8'h01);

    // R8 suspend
    wr_b(8'h56, 8'h00);
    rd_b(8'h56, "R9 status suspend bit");
    idle(40);
    wr_b(8'h5C, 8'h00);
    idle(100);
    wr_b(8'h57, 8'h00);  // restart with 64
    idle(80);
    wr_b(8'h55, 8'h00);
    idle(300);
    chk("R8 indefinite", susp, 1);
    wr_b(8'h5D, 8'h00);
    chk("R8 resume", susp, 0);
    wr_b(8'h59, 8'h00);
    idle(20);
    wr_b(8'h5D, 8'h00);

    // R9 status
    busy = 1; running = 1;
    foreach (img[i]) if (stat_off(8'(i))) rd_b(8'(i), "R9 status");
    busy = 0;
    rd_b(8'h5F, "R9 running only");
    running = 0;

    // R10 vectors
    for (int i = 0; i < 32; i++) wr_b(8'(8'h60 + i), 8'(i * 7 + 3));
    for (int i = 0; i < 32; i++) rd_b(8'(8'h60 + i), "R10 vector");

    // R11 registers and mirror
    for (int i = 0; i < 48; i++) wr_b(8'(8'h80 + i), 8'(i * 5 + 1));
    for (int i = 0; i < 48; i++) rd_b(8'(8'hC0 + i), "R11 mirror read");
    wr_b(8'hC7, 8'hE4);
    rd_b(8'h87, "R11 mirror write");
    rd_b(8'hEF, "R11 last byte");

    // R12 unmapped
    wr_b(8'h00, 8'hFF); wr_b(8'h3F, 8'hFF); wr_b(8'h52, 8'hFF);
    wr_b(8'hB0, 8'hFF); wr_b(8'hBF, 8'hFF); wr_b(8'hF0, 8'hFF); wr_b(8'hFF, 8'hFF);
    foreach (img[i]) if (i < 8'h40 || (i >= 8'hB0 && i < 8'hC0) || i >= 8'hF0 ||
                         i == 8'h52 || i == 8'h58 || i == 8'h5A)
      rd_b(8'(i), "R12 unmapped");
    rd_b(8'h80, "R12 register intact");
    rd_b(8'h4F, "R12 field intact");

    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule